// File: doc/BRIEF.md
# Lifting Wavelet Step Sequencer

This block computes one level of a four-coefficient Daubechies wavelet split using the lifting method, on a set of 32 signed fixed-point samples. Software or an upstream agent writes the samples into an internal buffer through a simple write port. It then pulses `start`. The block produces 16 approximation values and 16 detail values, one pair at a time. Each pair comes with a single-cycle valid strobe and its pair index.

Inside, a control state machine walks a fixed list of thirteen micro-operations for every pair. The list is: fetch even, fetch odd, scale odd, first approximation, scale it, recall the previous approximation, scale the recalled value, first difference, first detail, look-ahead detail, second approximation, output scaling of the approximation, output scaling of the detail.

The machine issues each micro-operation as a one-cycle command to a register-level datapath. It waits for the datapath's completion status before it issues the next command. The neighbour terms need the previous approximation and the next detail. For that reason the sequence runs one pair ahead: iteration k computes the intermediate values for index k and emits the outputs for index k-1. The block makes 17 iterations in all.

Top module: `lifting_step_seq`

## Requirements
- R1: After synchronous reset, `busy`, `out_valid` and `done` are all low.
- R2: A sample write (`wr_en`, `wr_addr`, `wr_data`) stores the value only while `busy` is low; a write while busy leaves the stored sample unchanged for the next run.
- R3: `start` begins a run only when `busy` is low; a `start` pulse during a run has no effect on the outputs, their count or their timing.
- R4: Values are 16-bit two's complement Q4.12. Every constant product is floor((a*K)/4096), kept to 16 bits. The first approximation is s1[n] = x[2n] + P(x[2n+1], 7094).
- R5: The first detail is d1[n] = (x[2n+1] - P(s1[n], 1773)) - P(s1[n-1], -274), with s1[-1] taken as zero.
- R6: The second approximation is s2[n] = s1[n] + d1[n+1], with d1[16] taken as zero.
- R7: `out_update` equals P(s2[n], 2120) and `out_predict` equals P(d1[n], 7912).
- R8: Each micro-operation takes one issue cycle and one status cycle, so one pair takes 26 cycles. Counting clock edges from the edge that accepts `start`, pair n appears after edge 51+26n.
- R9: `out_valid` is a one-cycle pulse per pair, with `out_index` running 0 to 15 in order. `done` pulses for one cycle on the edge after the 16th pair, which is edge 442, and `busy` falls at that same edge.
- R10: Runs may follow one another with no gap in function: each new run clears the neighbour history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Sample write strobe |
| wr_addr | input | 5 | Sample index to write |
| wr_data | input | 16 | Q4.12 sample value |
| start | input | 1 | Begin a run on the stored set |
| busy | output | 1 | A run is in progress |
| out_valid | output | 1 | One-cycle strobe for an output pair |
| out_index | output | 4 | Pair index of the current outputs |
| out_update | output | 16 | Approximation output, Q4.12 |
| out_predict | output | 16 | Detail output, Q4.12 |
| done | output | 1 | One-cycle pulse after the last pair |

## Verification
The embedded assertions watch the handshake on every cycle: only one command is in flight, each status follows a command, each output strobe follows the output-scaling command and lasts one cycle, and `done` coincides with the controller going idle. The numerical chain cannot be seen that way. Only the bench's scenarios can show it: the neighbour zeros at the two ends, the rounding of each product, the cycle at which each pair appears, and the fact that late writes and late starts are ignored. The bench compares every output pair against a model built from the stated formulas and constants.

// File: rtl/lws_pkg.sv
package lws_pkg;
    localparam int DATA_W = 16;
    localparam int FRAC_W = 12;
    localparam int PROD_W = 2 * DATA_W;

    typedef logic signed [DATA_W-1:0] sample_t;
    typedef logic signed [PROD_W-1:0] prod_t;

    // Q4.12 constants
    localparam sample_t K_RT3     = 16'sd7094;   // sqrt(3)
    localparam sample_t K_RT3B4   = 16'sd1773;   // sqrt(3)/4
    localparam sample_t K_RT3M2B4 = -16'sd274;   // (sqrt(3)-2)/4
    localparam sample_t K_UPD     = 16'sd2120;   // (sqrt(3)-1)/sqrt(2)
    localparam sample_t K_PRD     = 16'sd7912;   // (sqrt(3)+1)/sqrt(2)

    typedef enum logic [3:0] {
        OP_LD_EVEN = 4'd0,
        OP_LD_ODD  = 4'd1,
        OP_SC_ODD  = 4'd2,
        OP_S1      = 4'd3,
        OP_SC_S1   = 4'd4,
        OP_DLY_S1  = 4'd5,
        OP_SC_DLY  = 4'd6,
        OP_DIFF    = 4'd7,
        OP_D1      = 4'd8,
        OP_ADV_D   = 4'd9,
        OP_S2      = 4'd10,
        OP_UPD     = 4'd11,
        OP_PRD     = 4'd12
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } ctrl_st_e;

    // Fixed-point product, floor of the scaled result, wrapped to DATA_W
    function automatic sample_t qmul(input sample_t a, input sample_t k);
        return sample_t'((prod_t'(a) * prod_t'(k)) >>> FRAC_W);
    endfunction
endpackage

// File: rtl/lws_sample_buf.sv
module lws_sample_buf
    import lws_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              busy,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  sample_t           wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output sample_t           rd_data
);
    sample_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && !busy) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/lws_ctrl.sv
module lws_ctrl
    import lws_pkg::*;
#(
    parameter int NUM_PAIRS  = 16,
    parameter int PAIR_CNT_W = $clog2(NUM_PAIRS + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  status,
    output logic                  cmd_fire,
    output op_e                   cmd_op,
    output logic [PAIR_CNT_W-1:0] cmd_k,
    output logic                  cmd_last,
    output logic                  cmd_emit,
    output logic                  clr,
    output logic                  busy,
    output logic                  done
);
    localparam logic [PAIR_CNT_W-1:0] LAST_K = PAIR_CNT_W'(NUM_PAIRS);

    ctrl_st_e              st;
    op_e                   op;
    logic [PAIR_CNT_W-1:0] k;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            op   <= OP_LD_EVEN;
            k    <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        k  <= '0;
                        op <= OP_LD_EVEN;
                        st <= ST_ISSUE;
                    end
                end
                ST_ISSUE: st <= ST_WAIT;
                ST_WAIT: begin
                    if (status) begin
                        if (op == OP_PRD) begin
                            if (k == LAST_K) begin
                                st   <= ST_IDLE;
                                done <= 1'b1;
                            end else begin
                                k  <= k + PAIR_CNT_W'(1);
                                op <= OP_LD_EVEN;
                                st <= ST_ISSUE;
                            end
                        end else begin
                            op <= op_e'(op + 4'd1);
                            st <= ST_ISSUE;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign cmd_fire = (st == ST_ISSUE);
    assign cmd_op   = op;
    assign cmd_k    = k;
    assign cmd_last = (k == LAST_K);
    assign cmd_emit = (k != '0);
    assign clr      = (st == ST_IDLE) && start;
    assign busy     = (st != ST_IDLE);

    // R8: a new command never follows a command without a status cycle between
    assert_one_op_inflight_R8: assert property (@(posedge clk) disable iff (rst)
        cmd_fire |=> !cmd_fire);

    // R9: completion pulse only once the controller is back to idle
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

// File: rtl/lws_datapath.sv
module lws_datapath
    import lws_pkg::*;
#(
    parameter int NUM_PAIRS  = 16,
    parameter int PAIR_CNT_W = $clog2(NUM_PAIRS + 1),
    parameter int ADDR_W     = $clog2(2 * NUM_PAIRS),
    parameter int IDX_W      = $clog2(NUM_PAIRS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  cmd_fire,
    input  op_e                   cmd_op,
    input  logic [PAIR_CNT_W-1:0] cmd_k,
    input  logic                  cmd_last,
    input  logic                  cmd_emit,
    output logic [ADDR_W-1:0]     rd_addr,
    input  sample_t               rd_data,
    output logic                  status,
    output logic                  out_valid,
    output logic [IDX_W-1:0]      out_index,
    output sample_t               out_update,
    output sample_t               out_predict
);
    sample_t xe, xo, rt3_xo, s1, s1_q, s1_old, s1_dly, dly_q;
    sample_t diff1, d1, d_adv, d_old, s2;

    assign rd_addr = {cmd_k[ADDR_W-2:0], (cmd_op == OP_LD_ODD)};

    always_ff @(posedge clk) begin
        if (rst) begin
            xe <= '0; xo <= '0; rt3_xo <= '0; s1 <= '0; s1_q <= '0;
            s1_old <= '0; s1_dly <= '0; dly_q <= '0; diff1 <= '0;
            d1 <= '0; d_adv <= '0; d_old <= '0; s2 <= '0;
            out_update <= '0; out_predict <= '0; out_index <= '0;
            out_valid <= 1'b0;
            status    <= 1'b0;
        end else begin
            status    <= cmd_fire;
            out_valid <= 1'b0;
            if (clr) begin
                s1_old <= '0;
                d_old  <= '0;
            end
            if (cmd_fire) begin
                unique case (cmd_op)
                    OP_LD_EVEN: xe     <= cmd_last ? '0 : rd_data;
                    OP_LD_ODD:  xo     <= cmd_last ? '0 : rd_data;
                    OP_SC_ODD:  rt3_xo <= qmul(xo, K_RT3);
                    OP_S1:      s1     <= xe + rt3_xo;
                    OP_SC_S1:   s1_q   <= qmul(s1, K_RT3B4);
                    OP_DLY_S1:  s1_dly <= s1_old;
                    OP_SC_DLY:  dly_q  <= qmul(s1_dly, K_RT3M2B4);
                    OP_DIFF:    diff1  <= xo - s1_q;
                    OP_D1:      d1     <= diff1 - dly_q;
                    OP_ADV_D:   d_adv  <= cmd_last ? '0 : d1;
                    OP_S2:      s2     <= s1_dly + d_adv;
                    OP_UPD:     out_update <= qmul(s2, K_UPD);
                    OP_PRD: begin
                        out_predict <= qmul(d_old, K_PRD);
                        d_old       <= d1;
                        s1_old      <= s1;
                        if (cmd_emit) begin
                            out_valid <= 1'b1;
                            out_index <= IDX_W'(cmd_k - PAIR_CNT_W'(1));
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R8: status answers exactly one earlier command
    assert_status_follows_fire_R8: assert property (@(posedge clk) disable iff (rst)
        status |-> $past(cmd_fire));

    // R9: each output strobe lasts a single cycle
    assert_valid_single_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R8: an output strobe only follows the detail-scaling command
    assert_valid_after_predict_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(cmd_fire && (cmd_op == OP_PRD)));
endmodule

// File: rtl/lifting_step_seq.sv
module lifting_step_seq
    import lws_pkg::*;
#(
    parameter int NUM_SAMPLES = 32,
    parameter int ADDR_W      = $clog2(NUM_SAMPLES),
    parameter int IDX_W       = $clog2(NUM_SAMPLES / 2)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic                   start,
    output logic                   busy,
    output logic                   out_valid,
    output logic [IDX_W-1:0]       out_index,
    output logic [DATA_W-1:0]      out_update,
    output logic [DATA_W-1:0]      out_predict,
    output logic                   done
);
    localparam int NUM_PAIRS  = NUM_SAMPLES / 2;
    localparam int PAIR_CNT_W = $clog2(NUM_PAIRS + 1);

    logic                  cmd_fire, cmd_last, cmd_emit, clr, status;
    op_e                   cmd_op;
    logic [PAIR_CNT_W-1:0] cmd_k;
    logic [ADDR_W-1:0]     rd_addr;
    sample_t               rd_data, upd_q, prd_q;

    lws_sample_buf #(.DEPTH(NUM_SAMPLES), .ADDR_W(ADDR_W)) u_buf (
        .clk     (clk),
        .busy    (busy),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (sample_t'(wr_data)),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    lws_ctrl #(.NUM_PAIRS(NUM_PAIRS), .PAIR_CNT_W(PAIR_CNT_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .status   (status),
        .cmd_fire (cmd_fire),
        .cmd_op   (cmd_op),
        .cmd_k    (cmd_k),
        .cmd_last (cmd_last),
        .cmd_emit (cmd_emit),
        .clr      (clr),
        .busy     (busy),
        .done     (done)
    );

    lws_datapath #(
        .NUM_PAIRS(NUM_PAIRS), .PAIR_CNT_W(PAIR_CNT_W),
        .ADDR_W(ADDR_W), .IDX_W(IDX_W)
    ) u_dp (
        .clk         (clk),
        .rst         (rst),
        .clr         (clr),
        .cmd_fire    (cmd_fire),
        .cmd_op      (cmd_op),
        .cmd_k       (cmd_k),
        .cmd_last    (cmd_last),
        .cmd_emit    (cmd_emit),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .status      (status),
        .out_valid   (out_valid),
        .out_index   (out_index),
        .out_update  (upd_q),
        .out_predict (prd_q)
    );

    assign out_update  = upd_q;
    assign out_predict = prd_q;
endmodule

// File: tb/tb_lifting_step_seq.sv
module tb_lifting_step_seq;
    typedef struct packed {
        logic [3:0]         idx;
        logic signed [15:0] u;
        logic signed [15:0] p;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        start = 1'b0;
    logic        busy, out_valid, done;
    logic [3:0]  out_index;
    logic [15:0] out_update, out_predict;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int t0 = 0;
    int vcount = 0;
    bit done_seen = 1'b0;
    string cur_tag = "R7";
    logic signed [15:0] model_mem [32];
    exp_t exp_q [$];

    lifting_step_seq dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .start(start), .busy(busy), .out_valid(out_valid), .out_index(out_index),
        .out_update(out_update), .out_predict(out_predict), .done(done)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic signed [15:0] qm(input logic signed [15:0] a, input int k);
        logic signed [31:0] pr;
        pr = 32'(a) * k;
        return pr[27:12];
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, expv, $time);
        end
    endtask

    function automatic int pattern_value(input int p, input int i);
        case (p)
            0: return (i - 16) * 128;
            1: return (i % 2 == 1) ? -3000 : 3500;
            2: return (i == 0) ? 4096 : 0;
            3: return (i == 31) ? -4096 : 0;
            default: return (i % 3 == 0) ? 4096 : -4096;
        endcase
    endfunction

    task automatic write_sample(input int a, input int v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = 16'(v);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_set(input int p);
        for (int i = 0; i < 32; i++) begin
            write_sample(i, pattern_value(p, i));
            model_mem[i] = 16'(pattern_value(p, i));
        end
    endtask

    // Driver side of the scoreboard: expected pairs from the requirement formulas
    task automatic push_expected();
        logic signed [15:0] s1 [17];
        logic signed [15:0] d1 [17];
        logic signed [15:0] prev, s2;
        exp_t e;
        prev = '0;                                  // R5: s1[-1] = 0
        for (int n = 0; n < 16; n++) begin
            s1[n] = model_mem[2*n] + qm(model_mem[2*n+1], 7094);
            d1[n] = (model_mem[2*n+1] - qm(s1[n], 1773)) - qm(prev, -274);
            prev = s1[n];
        end
        d1[16] = '0;                                // R6: d1[16] = 0
        for (int n = 0; n < 16; n++) begin
            s2 = s1[n] + d1[n+1];
            e.idx = 4'(n);
            e.u = qm(s2, 2120);
            e.p = qm(d1[n], 7912);
            exp_q.push_back(e);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        t0 = cyc;
        vcount = 0;
        done_seen = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done_seen) @(negedge clk);
        check(exp_q.size() == 0, "R9 all pairs delivered", exp_q.size(), 0);
        check(vcount == 16, "R9 pair count", vcount, 16);
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R9 idle after done", busy, 0);
    endtask

    task automatic run_set(input string tag);
        cur_tag = tag;
        push_expected();
        pulse_start();
        wait_done();
    endtask

    // Monitor side of the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected pair", vcount, -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(out_index == e.idx, {cur_tag, " R9 index"}, out_index, e.idx);
                    check($signed(out_update) == e.u, {cur_tag, " R6 R7 update"},
                          $signed(out_update), e.u);
                    check($signed(out_predict) == e.p, {cur_tag, " R5 R7 predict"},
                          $signed(out_predict), e.p);
                    check(cyc - t0 == 52 + 26 * int'(e.idx), "R8 pair timing",
                          cyc - t0, 52 + 26 * int'(e.idx));
                end
                vcount++;
            end
            if (done) begin
                check(cyc - t0 == 443, "R9 done timing", cyc - t0, 443);
                done_seen = 1'b1;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R8 watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
        check(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);
        check(done == 1'b0, "R1 done after reset", done, 0);

        load_set(0);
        run_set("R4 ramp");
        load_set(1);
        run_set("R4 alternating");
        load_set(2);
        run_set("R5 first-sample impulse");
        load_set(3);
        run_set("R6 last-sample impulse");
        load_set(4);
        run_set("R7 full-scale mix");

        // R2: write during a run must not reach the buffer; R3: late start ignored
        cur_tag = "R3 start while busy";
        push_expected();
        pulse_start();
        repeat (100) @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'd0; wr_data = 16'h7FFF;
        @(negedge clk);
        wr_en = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();

        // R10: back-to-back run on the same set; R2: value at index 0 still original
        run_set("R2 R10 rerun after busy write");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule